// File: doc/BRIEF.md
# Exception Cause Priority Selector

This combinational block takes a vector of pending trap flags, one bit per cause number, and reports which single cause should be taken. A mode input first filters the vector down to the causes that one kind of source can raise (instruction fetch, load unit, store unit, atomic unit). The same mode input can also keep every defined cause, or pass the raw vector unchanged.

The filtered vector is then scanned in a fixed order of importance, which is not numeric order. A breakpoint outranks everything else. Fetch-side faults come next, then environment calls. Among the data-side faults, misalignment comes before page faults, page faults come before access faults, and a store comes before a load of the same kind.

The block exposes the filtered vector, a valid flag and the 4-bit winning cause number. A retirement or commit stage uses it to record one cause per instruction.

Top module: `exc_cause_select`

## Requirements
- R1: With mode code 0 (pass), the filtered output equals the raw input bit for bit.
- R2: With mode code 1 (all defined), the filtered output is the raw input with bits 10 and 14 forced to zero (mask 16'hBBFF).
- R3: With mode code 2 (fetch), only bits 0, 1, 2 and 12 survive (mask 16'h1007).
- R4: With mode code 3 (load), only bits 4, 5 and 13 survive (mask 16'h2030).
- R5: With mode code 4 (store), only bits 6, 7 and 15 survive (mask 16'h80C0).
- R6: With mode code 5 (atomic), the union of the load and store bits survives (mask 16'hA0F0).
- R7: Mode codes 6 and 7 are reserved. They clear the whole filtered vector, so valid is low.
- R8: The reported cause is the first set bit of the filtered vector in this order, from highest to lowest: 3, 12, 1, 2, 0, 11, 9, 8, 6, 4, 15, 13, 7, 5. The undefined indices rank after all of these, 10 before 14; they can only win in pass mode.
- R9: Valid is high exactly when any bit of the filtered vector is set.
- R10: When valid is low, the cause output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exc_raw_i | input | 16 | Pending trap flags, bit n is cause number n |
| mode_i | input | 3 | Filter mode code (0 pass, 1 all, 2 fetch, 3 load, 4 store, 5 atomic, 6/7 reserved) |
| exc_filt_o | output | 16 | Raw vector after the mode filter |
| exc_valid_o | output | 1 | Some filtered bit is set |
| exc_cause_o | output | 4 | Cause number of the highest ranked filtered bit, zero when invalid |

## Verification
The bench's corner cases are the pairs where numeric order and rank disagree. A selector that simply takes the lowest set bit would pick cause 0 over breakpoint 3, and load page fault 13 over store page fault 15. It would also pick load access fault 5 over store misaligned 6.

Every single bit is driven under every mode. A wrong mask shows up as a bit that leaks into the filtered vector or is dropped from it. Sweeping every single bit also catches a stale cause left behind when valid falls.

The reserved mode codes and the undefined indices 10 and 14 are exercised too. A design that let them through in the all-defined mode would report an invalid cause number.

// File: rtl/exc_sel_pkg.sv
package exc_sel_pkg;

   localparam int unsigned NCAUSE  = 16;
   localparam int unsigned CAUSE_W = $clog2(NCAUSE);

   typedef enum logic [2:0] {
      MODE_PASS   = 3'd0,
      MODE_ALL    = 3'd1,
      MODE_FETCH  = 3'd2,
      MODE_LOAD   = 3'd3,
      MODE_STORE  = 3'd4,
      MODE_ATOMIC = 3'd5,
      MODE_RSV6   = 3'd6,
      MODE_RSV7   = 3'd7
   } mask_mode_e;

   localparam logic [NCAUSE-1:0] KEEP_FETCH = 16'h1007;
   localparam logic [NCAUSE-1:0] KEEP_LOAD  = 16'h2030;
   localparam logic [NCAUSE-1:0] KEEP_STORE = 16'h80C0;
   localparam logic [NCAUSE-1:0] KEEP_ALL   = 16'hBBFF;

   function automatic logic [NCAUSE-1:0] mode_keep(mask_mode_e m);
      logic [NCAUSE-1:0] k;
      case (m)
         MODE_PASS:   k = '1;
         MODE_ALL:    k = KEEP_ALL;
         MODE_FETCH:  k = KEEP_FETCH;
         MODE_LOAD:   k = KEEP_LOAD;
         MODE_STORE:  k = KEEP_STORE;
         MODE_ATOMIC: k = KEEP_LOAD | KEEP_STORE;
         default:     k = '0;
      endcase
      return k;
   endfunction

   // rank 0 is the most important cause
   function automatic logic [CAUSE_W-1:0] rank_cause(int unsigned r);
      logic [CAUSE_W-1:0] c;
      case (r)
         0:       c = 4'd3;
         1:       c = 4'd12;
         2:       c = 4'd1;
         3:       c = 4'd2;
         4:       c = 4'd0;
         5:       c = 4'd11;
         6:       c = 4'd9;
         7:       c = 4'd8;
         8:       c = 4'd6;
         9:       c = 4'd4;
         10:      c = 4'd15;
         11:      c = 4'd13;
         12:      c = 4'd7;
         13:      c = 4'd5;
         14:      c = 4'd10;
         default: c = 4'd14;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/exc_mask_filter.sv
module exc_mask_filter
   import exc_sel_pkg::*;
#(
   parameter int unsigned N = NCAUSE
) (
   input  logic [N-1:0] raw_i,
   input  mask_mode_e   mode_i,
   output logic [N-1:0] filt_o
);
   logic [NCAUSE-1:0] keep;

   assign keep = mode_keep(mode_i);

   for (genvar i = 0; i < N; i++) begin : g_bit
      assign filt_o[i] = raw_i[i] & keep[i];
   end
endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick
   import exc_sel_pkg::*;
#(
   parameter int unsigned N  = NCAUSE,
   parameter int unsigned CW = CAUSE_W
) (
   input  logic [N-1:0]  vec_i,
   output logic [N-1:0]  grant_o,
   output logic          valid_o,
   output logic [CW-1:0] cause_o
);
   always_comb begin
      grant_o = '0;
      cause_o = '0;
      // scan from lowest rank up so a more important hit overrides
      for (int r = N - 1; r >= 0; r--) begin
         if (vec_i[rank_cause(unsigned'(r))]) begin
            grant_o = '0;
            grant_o[rank_cause(unsigned'(r))] = 1'b1;
            cause_o = rank_cause(unsigned'(r));
         end
      end
      valid_o = |vec_i;
   end
endmodule

// File: rtl/exc_cause_select.sv
module exc_cause_select
   import exc_sel_pkg::*;
#(
   parameter int unsigned NUM_CAUSE = NCAUSE
) (
   input  logic [NUM_CAUSE-1:0]         exc_raw_i,
   input  logic [2:0]                   mode_i,
   output logic [NUM_CAUSE-1:0]         exc_filt_o,
   output logic                         exc_valid_o,
   output logic [$clog2(NUM_CAUSE)-1:0] exc_cause_o
);
   localparam int unsigned CW = $clog2(NUM_CAUSE);

   if (NUM_CAUSE != NCAUSE) begin : g_bad_width
      $error("exc_cause_select: NUM_CAUSE must match the cause map width");
   end

   logic [NUM_CAUSE-1:0] pick_grant;

   exc_mask_filter #(.N(NUM_CAUSE)) u_filter (
      .raw_i  (exc_raw_i),
      .mode_i (mask_mode_e'(mode_i)),
      .filt_o (exc_filt_o)
   );

   exc_prio_pick #(.N(NUM_CAUSE), .CW(CW)) u_pick (
      .vec_i   (exc_filt_o),
      .grant_o (pick_grant),
      .valid_o (exc_valid_o),
      .cause_o (exc_cause_o)
   );
endmodule

// File: rtl/exc_cause_select_chk.sv
module exc_cause_select_chk (
   input logic [15:0] raw,
   input logic [2:0]  mode,
   input logic [15:0] filt,
   input logic        valid,
   input logic [3:0]  cause,
   input logic [15:0] grant
);
   always_comb begin
      assert_filt_subset_R1: assert ((filt & ~raw) == 16'h0);
      if (mode == 3'd1)
         assert_undef_cleared_R2: assert ((filt & 16'h4400) == 16'h0);
      if (mode == 3'd2)
         assert_fetch_only_R3: assert ((filt & ~16'h1007) == 16'h0);
      if (mode == 3'd5)
         assert_atomic_only_R6: assert ((filt & ~16'hA0F0) == 16'h0);
      if (mode[2:1] == 2'b11)
         assert_reserved_empty_R7: assert (filt == 16'h0);
      assert_grant_onehot_R8: assert ($onehot0(grant));
      if (valid)
         assert_cause_pending_R8: assert (filt[cause] && grant[cause]);
      assert_valid_any_R9: assert (valid == (filt != 16'h0));
      if (!valid)
         assert_idle_cause_R10: assert (cause == 4'd0 && grant == 16'h0);
   end
endmodule

bind exc_cause_select exc_cause_select_chk u_chk (
   .raw   (exc_raw_i),
   .mode  (mode_i),
   .filt  (exc_filt_o),
   .valid (exc_valid_o),
   .cause (exc_cause_o),
   .grant (pick_grant)
);

// File: tb/test_exc_cause_select.sv
`timescale 1ns/1ps
module test_exc_cause_select;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] raw = 16'h0;
   logic [2:0]  mode = 3'd0;
   logic [15:0] filt;
   logic        valid;
   logic [3:0]  cause;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   exc_cause_select i_exc_cause_select (
      .exc_raw_i   (raw),
      .mode_i      (mode),
      .exc_filt_o  (filt),
      .exc_valid_o (valid),
      .exc_cause_o (cause)
   );

   // reference model built from the requirement text
   function automatic logic [15:0] ref_mask(logic [2:0] m);
      case (m)
         3'd0:    return 16'hFFFF; // R1
         3'd1:    return 16'hBBFF; // R2
         3'd2:    return 16'h1007; // R3
         3'd3:    return 16'h2030; // R4
         3'd4:    return 16'h80C0; // R5
         3'd5:    return 16'hA0F0; // R6
         default: return 16'h0000; // R7
      endcase
   endfunction

   function automatic logic [3:0] ref_cause(logic [15:0] v);
      int order [16] = '{3, 12, 1, 2, 0, 11, 9, 8, 6, 4, 15, 13, 7, 5, 10, 14};
      for (int k = 0; k < 16; k++)
         if (v[order[k]]) return 4'(order[k]);
      return 4'd0; // R10
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s raw=%h mode=%0d actual=%h expected=%h", req, raw, mode, act, exp);
      end
   endtask

   task automatic apply(input logic [15:0] v, input logic [2:0] m);
      @(negedge clk);
      raw  = v;
      mode = m;
      #1;
   endtask

   task automatic check_all(input string tag);
      logic [15:0] ef;
      ef = raw & ref_mask(mode);
      chk({tag, " R1-filter"}, {16'h0, filt}, {16'h0, ef});
      chk({tag, " R9"}, {31'h0, valid}, {31'h0, (ef != 16'h0)});
      chk({tag, " R8/R10"}, {28'h0, cause}, {28'h0, ref_cause(ef)});
   endtask

   task automatic t_idle;
      apply(16'h0, 3'd0);
      chk("idle R9", {31'h0, valid}, 32'h0);
      chk("idle R10", {28'h0, cause}, 32'h0);
   endtask

   task automatic t_single_bits;
      for (int m = 0; m < 8; m++)
         for (int b = 0; b < 16; b++) begin
            apply(16'h1 << b, 3'(m));
            check_all("single R2 R3 R4 R5 R6");
         end
   endtask

   task automatic t_rank_pairs;
      apply(16'h0009, 3'd1);
      chk("breakpoint over 0 R8", {28'h0, cause}, 32'd3);
      apply(16'hA000, 3'd3);
      chk("load mode hides 15 R4", {28'h0, cause}, 32'd13);
      apply(16'hA000, 3'd5);
      chk("store PF over load PF R6", {28'h0, cause}, 32'd15);
      apply(16'h00A0, 3'd4);
      chk("store mode R5", {28'h0, cause}, 32'd7);
      apply(16'h0060, 3'd5);
      chk("store misalign over load AF R8", {28'h0, cause}, 32'd6);
      apply(16'h4400, 3'd1);
      chk("undef cleared R2", {31'h0, valid}, 32'h0);
      apply(16'h4400, 3'd0);
      chk("undef rank in pass R1", {28'h0, cause}, 32'd10);
      apply(16'hFFFF, 3'd6);
      chk("reserved R7", {16'h0, filt}, 32'h0);
      apply(16'hFFFF, 3'd7);
      chk("reserved R7 valid", {31'h0, valid}, 32'h0);
      apply(16'hFFFF, 3'd2);
      chk("fetch R3", {28'h0, cause}, 32'd12);
   endtask

   task automatic t_random;
      for (int n = 0; n < 400; n++) begin
         apply(16'($urandom), 3'(n % 8));
         check_all("random");
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_idle();
      t_single_bits();
      t_rank_pairs();
      t_random();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule